// File: doc/BRIEF.md
# IO Translation Control Register File

This block is the software-visible register bank that sits beside an IO address-translation engine. A 32-bit register bus addresses it by word (the byte offset shifted right by two) with separate write and read strobes. Every register keeps only the bits its mask allows. Some registers also merge in fixed constants. The stored contents drive the translation engine directly as an enable bit, a page-table base, per-slot configuration bits and the lowest address of the translated IO window.

The window start comes from a 3-bit size code in the control register. It is computed when control is written and then held in its own register. That register clears to zero at reset, and the code is not applied until the first control write. The fault status and fault address registers can be written from the bus. The translation engine loads them through a one-cycle capture port when it rejects an access. The two flush registers only hold what software writes to them. Nothing in the block acts on their values.

Top module: `iox_ctrl_regs`

## Requirements
- R1: Control (word 0x000) keeps written bits under mask 0x0000001D and reads back ORed with 0x04000000. Bit 0 drives `xlate_en` from the cycle after the write.
- R2: A control write sets `win_start` to 0xFFFFFFFF shifted left by (24 + code), where code is written bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. `win_start` changes on no other event, and it is valid from the cycle after the write.
- R3: The page-table base (word 0x001) keeps mask 0x07FFFC00 and is driven on `pt_base`.
- R4: The two flush registers (words 0x005 and 0x006) store all 32 written bits. Writing them changes no output.
- R5: Slot n configuration (word 0x404+n, for n from 0 to 3) keeps mask 0x00010003. Its bit 0 drives `slot_bypass[n]`, bit 1 drives `slot_burst8[n]` and bit 16 drives `slot_pa30[n]`.
- R6: The arbitration register (word 0x800) keeps mask 0x001F0000, and every write also sets bit 3.
- R7: When `cap_valid` is high, fault status loads 0xC0820000 for a write fault or 0xC0860000 for a read fault, and fault address loads `cap_addr`. A capture overrides a bus write to either register in the same cycle.
- R8: Fault status (word 0x400) and fault address (word 0x401) store the full 32 bits of a bus write.
- R9: `bus_rdata` shows the addressed register in the cycle after `bus_rd` and holds between reads. A read in the same cycle as a write to the same word returns the old value. Words with no register read as zero, and writes to them change nothing.
- R10: Synchronous reset clears every register, `win_start` and `bus_rdata` to zero, except control, which reads 0x04000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_valid | input | 1 | Fault capture strobe from the translation engine |
| cap_is_write | input | 1 | Faulting access was a write |
| cap_addr | input | 32 | Faulting page address |
| xlate_en | output | 1 | Translation enable |
| win_start | output | 32 | Lowest address of the translated window |
| pt_base | output | 32 | Page-table base, masked |
| slot_bypass | output | 4 | Per-slot bypass |
| slot_burst8 | output | 4 | Per-slot 8-byte burst allowed |
| slot_pa30 | output | 4 | Per-slot physical address bit 30 for bypass |

## Verification
Any register that holds a wrong masked value shows it on the bus one cycle after the next read of its word. Registers that feed the engine also show it on their output pins in the cycle right after the write that caused it. A window start taken from the wrong code, or updated on a write to another word, changes `win_start` within one cycle. A capture that loses priority or sets the wrong read/write flag shows up on the first read of the fault words. The bench keeps a behavioural model of every word and compares all outputs on every clock, so a corrupted state is seen no later than the first read that follows it.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int DATA_W = 32;

    // Word addresses (byte offset >> 2)
    localparam int W_CTRL  = 'h000;
    localparam int W_BASE  = 'h001;
    localparam int W_TLBF  = 'h005;
    localparam int W_PGF   = 'h006;
    localparam int W_FSR   = 'h400;
    localparam int W_FAR   = 'h401;
    localparam int W_SLOT0 = 'h404;
    localparam int W_ARB   = 'h800;

    // Masks and fixed values
    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0000_001D;
    localparam logic [DATA_W-1:0] CTRL_VER  = 32'h0400_0000;
    localparam logic [DATA_W-1:0] BASE_KEEP = 32'h07FF_FC00;
    localparam logic [DATA_W-1:0] SLOT_KEEP = 32'h0001_0003;
    localparam logic [DATA_W-1:0] ARB_KEEP  = 32'h001F_0000;
    localparam logic [DATA_W-1:0] ARB_ID    = 32'h0000_0008;
    localparam logic [DATA_W-1:0] FLT_WORD  = 32'hC082_0000;
    localparam logic [DATA_W-1:0] FLT_RDBIT = 32'h0004_0000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF,
        SEL_FSR, SEL_FAR, SEL_SLOT, SEL_ARB
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              is_write;
        logic [DATA_W-1:0] addr;
    } fault_cap_t;

    typedef struct packed {
        logic pa30;
        logic burst8;
        logic bypass;
    } slot_cfg_t;

    // Lowest address of a window that ends at the top of the space
    function automatic logic [DATA_W-1:0] window_start(input logic [2:0] code);
        logic [4:0] sh;
        sh = 5'd24 + {2'b00, code};
        return {DATA_W{1'b1}} << sh;
    endfunction

    function automatic slot_cfg_t slot_fields(input logic [DATA_W-1:0] r);
        slot_cfg_t c;
        c.bypass = r[0];
        c.burst8 = r[1];
        c.pa30   = r[16];
        return c;
    endfunction

endpackage

// File: rtl/iox_addr_decode.sv
module iox_addr_decode
    import iox_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    localparam int SIW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [SIW-1:0]    slot_idx
);
    localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'(W_SLOT0);
    localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'(W_SLOT0 + NUM_SLOTS);

    always_comb begin
        sel      = SEL_NONE;
        slot_idx = '0;
        if (addr == ADDR_W'(W_CTRL))      sel = SEL_CTRL;
        else if (addr == ADDR_W'(W_BASE)) sel = SEL_BASE;
        else if (addr == ADDR_W'(W_TLBF)) sel = SEL_TLBF;
        else if (addr == ADDR_W'(W_PGF))  sel = SEL_PGF;
        else if (addr == ADDR_W'(W_FSR))  sel = SEL_FSR;
        else if (addr == ADDR_W'(W_FAR))  sel = SEL_FAR;
        else if (addr == ADDR_W'(W_ARB))  sel = SEL_ARB;
        else if (addr >= SLOT_LO && addr < SLOT_HI) begin
            sel      = SEL_SLOT;
            slot_idx = SIW'(addr - SLOT_LO);
        end
    end
endmodule

// File: rtl/iox_window_map.sv
module iox_window_map
    import iox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic              xlate_en,
    output logic [DATA_W-1:0] win_start
);
    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            win_start <= '0;
        end else if (wr_en) begin
            ctrl_q    <= wdata & CTRL_KEEP;
            win_start <= window_start(wdata[4:2]);
        end
    end

    assign ctrl_rd  = ctrl_q | CTRL_VER;
    assign xlate_en = ctrl_q[0];

    AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (xlate_en == $past(wdata[0]))); // R1
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(win_start)); // R2
endmodule

// File: rtl/iox_fault_store.sv
module iox_fault_store
    import iox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fsr,
    input  logic              wr_far,
    input  logic [DATA_W-1:0] wdata,
    input  fault_cap_t        cap,
    output logic [DATA_W-1:0] fsr_q,
    output logic [DATA_W-1:0] far_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
            far_q <= '0;
        end else if (cap.valid) begin
            fsr_q <= FLT_WORD | (cap.is_write ? '0 : FLT_RDBIT);
            far_q <= cap.addr;
        end else begin
            if (wr_fsr) fsr_q <= wdata;
            if (wr_far) far_q <= wdata;
        end
    end

    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (rst)
        cap.valid |=> (fsr_q[31] && far_q == $past(cap.addr))); // R7
    AST_CAP_RDFLAG: assert property (@(posedge clk) disable iff (rst)
        cap.valid |=> (fsr_q[18] == !$past(cap.is_write))); // R7
endmodule

// File: rtl/iox_ctrl_regs.sv
module iox_ctrl_regs
    import iox_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    localparam int SIW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 cap_valid,
    input  logic                 cap_is_write,
    input  logic [DATA_W-1:0]    cap_addr,
    output logic                 xlate_en,
    output logic [DATA_W-1:0]    win_start,
    output logic [DATA_W-1:0]    pt_base,
    output logic [NUM_SLOTS-1:0] slot_bypass,
    output logic [NUM_SLOTS-1:0] slot_burst8,
    output logic [NUM_SLOTS-1:0] slot_pa30
);
    reg_sel_e          sel;
    logic [SIW-1:0]    slot_idx;
    logic [DATA_W-1:0] ctrl_rd, base_q, tlbf_q, pgf_q, arb_q, fsr_q, far_q;
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic [DATA_W-1:0] rd_val;
    fault_cap_t        cap;

    iox_addr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr(bus_addr), .sel(sel), .slot_idx(slot_idx)
    );

    iox_window_map u_win (
        .clk(clk), .rst(rst),
        .wr_en(bus_wr && sel == SEL_CTRL),
        .wdata(bus_wdata),
        .ctrl_rd(ctrl_rd), .xlate_en(xlate_en), .win_start(win_start)
    );

    assign cap = '{valid: cap_valid, is_write: cap_is_write, addr: cap_addr};

    iox_fault_store u_flt (
        .clk(clk), .rst(rst),
        .wr_fsr(bus_wr && sel == SEL_FSR),
        .wr_far(bus_wr && sel == SEL_FAR),
        .wdata(bus_wdata), .cap(cap),
        .fsr_q(fsr_q), .far_q(far_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            tlbf_q <= '0;
            pgf_q  <= '0;
            arb_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_BASE: base_q <= bus_wdata & BASE_KEEP;
                SEL_TLBF: tlbf_q <= bus_wdata;
                SEL_PGF:  pgf_q  <= bus_wdata;
                SEL_ARB:  arb_q  <= (bus_wdata & ARB_KEEP) | ARB_ID;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : gen_slot
        slot_cfg_t cfg;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (bus_wr && sel == SEL_SLOT && slot_idx == SIW'(g))
                slot_q[g] <= bus_wdata & SLOT_KEEP;
        end
        assign cfg            = slot_fields(slot_q[g]);
        assign slot_bypass[g] = cfg.bypass;
        assign slot_burst8[g] = cfg.burst8;
        assign slot_pa30[g]   = cfg.pa30;
    end

    assign pt_base = base_q;

    always_comb begin
        case (sel)
            SEL_CTRL: rd_val = ctrl_rd;
            SEL_BASE: rd_val = base_q;
            SEL_TLBF: rd_val = tlbf_q;
            SEL_PGF:  rd_val = pgf_q;
            SEL_FSR:  rd_val = fsr_q;
            SEL_FAR:  rd_val = far_q;
            SEL_SLOT: rd_val = slot_q[slot_idx];
            SEL_ARB:  rd_val = arb_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    AST_BASE_MASK: assert property (@(posedge clk) disable iff (rst)
        (pt_base & ~BASE_KEEP) == '0); // R3
    AST_ARB_ID: assert property (@(posedge clk) disable iff (rst)
        (arb_q != '0) |-> arb_q[3]); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0); // R9
endmodule

// File: tb/tb_iox_ctrl_regs.sv
module tb_iox_ctrl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_valid = 0, cap_is_write = 0;
    logic [31:0] cap_addr = '0;
    logic        xlate_en;
    logic [31:0] win_start, pt_base;
    logic [3:0]  slot_bypass, slot_burst8, slot_pa30;

    iox_ctrl_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_valid(cap_valid), .cap_is_write(cap_is_write), .cap_addr(cap_addr),
        .xlate_en(xlate_en), .win_start(win_start), .pt_base(pt_base),
        .slot_bypass(slot_bypass), .slot_burst8(slot_burst8), .slot_pa30(slot_pa30)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string phase = "R10 reset";

    // Behavioural model
    logic [31:0] m_ctrl, m_win, m_base, m_tlb, m_pg, m_fsr, m_far, m_arb, m_rd;
    logic [31:0] m_slot [4];

    task automatic model_reset();
        m_ctrl = 32'h0400_0000; m_win = 0; m_base = 0; m_tlb = 0; m_pg = 0;
        m_fsr = 0; m_far = 0; m_arb = 0; m_rd = 0;
        for (int i = 0; i < 4; i++) m_slot[i] = 0;
    endtask

    function automatic logic [31:0] model_read(input int a);
        if (a == 'h000) return m_ctrl;
        if (a == 'h001) return m_base;
        if (a == 'h005) return m_tlb;
        if (a == 'h006) return m_pg;
        if (a == 'h400) return m_fsr;
        if (a == 'h401) return m_far;
        if (a >= 'h404 && a <= 'h407) return m_slot[a - 'h404];
        if (a == 'h800) return m_arb;
        return 0;
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        if (a == 'h000) begin
            m_ctrl = (d & 32'h1D) | 32'h0400_0000;
            case (d[4:2])
                3'd0: m_win = 32'hFF00_0000;
                3'd1: m_win = 32'hFE00_0000;
                3'd2: m_win = 32'hFC00_0000;
                3'd3: m_win = 32'hF800_0000;
                3'd4: m_win = 32'hF000_0000;
                3'd5: m_win = 32'hE000_0000;
                3'd6: m_win = 32'hC000_0000;
                default: m_win = 32'h8000_0000;
            endcase
        end
        else if (a == 'h001) m_base = d & 32'h07FF_FC00;
        else if (a == 'h005) m_tlb = d;
        else if (a == 'h006) m_pg = d;
        else if (a == 'h400) m_fsr = d;
        else if (a == 'h401) m_far = d;
        else if (a >= 'h404 && a <= 'h407) m_slot[a - 'h404] = d & 32'h0001_0003;
        else if (a == 'h800) m_arb = (d & 32'h001F_0000) | 32'h8;
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", what, phase, act, exp);
        end
    endtask

    // Compare every output on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] eb, e8, e30;
            for (int i = 0; i < 4; i++) begin
                eb[i] = m_slot[i][0]; e8[i] = m_slot[i][1]; e30[i] = m_slot[i][16];
            end
            check("R1 xlate_en", {31'b0, xlate_en}, {31'b0, m_ctrl[0]});
            check("R2 win_start", win_start, m_win);
            check("R3 pt_base", pt_base, m_base);
            check("R5 slot_bypass", {28'b0, slot_bypass}, {28'b0, eb});
            check("R5 slot_burst8", {28'b0, slot_burst8}, {28'b0, e8});
            check("R5 slot_pa30", {28'b0, slot_pa30}, {28'b0, e30});
            check("R9 bus_rdata", bus_rdata, m_rd);
        end
    end

    // One bus cycle: drive at the falling edge, update model after the rising edge
    task automatic cycle(input logic wr, input logic rd, input int a, input logic [31:0] d,
                         input logic cv = 0, input logic cw = 0, input logic [31:0] ca = 0);
        bus_wr = wr; bus_rd = rd; bus_addr = 12'(a); bus_wdata = d;
        cap_valid = cv; cap_is_write = cw; cap_addr = ca;
        @(posedge clk);
        #1;
        if (rd) m_rd = model_read(a);
        if (wr) model_write(a, d);
        if (cv) begin
            m_fsr = 32'hC082_0000 | (cw ? 32'h0 : 32'h0004_0000);
            m_far = ca;
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; cap_valid = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d); cycle(1, 0, a, d); endtask
    task automatic rd(input int a); cycle(0, 1, a, 0); endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 0;
    endtask

    int addrs [10] = '{'h000, 'h001, 'h005, 'h006, 'h400, 'h401, 'h404, 'h405, 'h406, 'h800};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        phase = "R10 reset values";
        foreach (addrs[i]) rd(addrs[i]);
        rd('h407);

        phase = "R1 R2 control and window";
        wr('h000, 32'hFFFF_FFFF); rd('h000);
        for (int c = 0; c < 8; c++) begin
            wr('h000, 32'(c << 2) | 32'h1); rd('h000);
        end
        wr('h000, 32'hFFFF_FFE2); rd('h000);
        wr('h000, 32'h0000_0000); rd('h000);

        phase = "R3 page base";
        wr('h001, 32'hFFFF_FFFF); rd('h001);
        wr('h001, 32'h1234_5678); rd('h001);

        phase = "R4 flush store only";
        wr('h005, 32'hDEAD_BEEF); rd('h005);
        wr('h006, 32'h1234_5678); rd('h006);

        phase = "R5 slot config";
        wr('h404, 32'hFFFF_FFFF); wr('h405, 32'h0001_0000);
        wr('h406, 32'h0000_0002); wr('h407, 32'hFFFE_FFFD);
        for (int i = 0; i < 4; i++) rd('h404 + i);

        phase = "R6 arbitration";
        wr('h800, 32'h0); rd('h800);
        wr('h800, 32'hFFFF_FFFF); rd('h800);

        phase = "R8 fault bus write";
        wr('h400, 32'hA5A5_5A5A); wr('h401, 32'h0F0F_F0F0);
        rd('h400); rd('h401);

        phase = "R7 fault capture";
        cycle(0, 0, 0, 0, 1, 1, 32'h1234_5000); rd('h400); rd('h401);
        cycle(0, 0, 0, 0, 1, 0, 32'h8000_1000); rd('h400); rd('h401);
        cycle(1, 0, 'h400, 32'h1111_1111, 1, 1, 32'hCAFE_0000); rd('h400);
        cycle(1, 0, 'h401, 32'h2222_2222, 1, 0, 32'hBEEF_0000); rd('h401); rd('h400);

        phase = "R9 unmapped and read timing";
        wr('h003, 32'hFFFF_FFFF); wr('h7FF, 32'hFFFF_FFFF); wr('hFFF, 32'hFFFF_FFFF);
        rd('h003); rd('h7FF); rd('hFFF); rd('h002);
        foreach (addrs[i]) rd(addrs[i]);
        cycle(1, 1, 'h001, 32'h0000_0C00, 0, 0, 0); rd('h001);
        rd('h005);
        repeat (3) @(negedge clk);

        phase = "R10 reset mid-run";
        do_reset();
        foreach (addrs[i]) rd(addrs[i]);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule